// File: doc/BRIEF.md
# MDIO PHY Link Status Poller

This block scans a group of Ethernet PHYs over a two-wire management bus (MDC clock and MDIO data). It reads the basic status register of each chosen PHY address in turn. It keeps two 32-bit vectors indexed by PHY address. The presence vector shows which PHYs answered their most recent read. The link vector shows which PHYs answered and reported link up. Each polling round walks a 32-bit address mask from address 0 upwards. The gap between rounds is programmable in microsecond units and has a lower bound.

A mode bit can change where the link vector comes from. In pin mode, a set of per-port receive-link pins replaces the polled results. Each pin is synchronised and passes through its own polarity setting, then lands at a programmable PHY address. A sticky interrupt records every change of the link vector until software clears it.

Configuration uses a small write port with four word addresses. Status is read straight from the vector and interrupt outputs.

Top module: `mdio_link_poller`

## Requirements
- R1: When a PHY drives MDIO low in the second turnaround bit of a read, the presence bit at that PHY's address is set one clock after the frame ends.
- R2: When a read gets no acknowledge (MDIO high in the second turnaround bit), the presence bit at that address is cleared. Presence bits of addresses that are not polled keep their value.
- R3: Each read frame is sent in this order: 32 ones, start 0 then 1, opcode 1 then 0, the 5-bit PHY address MSB first, and register address 00001. The block then releases MDIO for 18 bits, which are two turnaround bits and 16 data bits. MDC has a period of 2*DIV_HALF clocks, MDIO changes while MDC is low, and MDC stays low between frames.
- R4: In polling mode, link bit N equals 1 only if the last read of PHY N was acknowledged and bit 2 of the returned status word is 1. Otherwise it is 0.
- R5: A round reads only the addresses whose mask bits are 1, in ascending address order, one frame at a time.
- R6: A new round starts max(interval, 10) * TICK_CYC clocks after the previous round has finished. The first MDC rise of the new round follows within 80 clocks of that point.
- R7: In pin mode, the link vector holds a 1 only at the configured address of each port whose adjusted pin is active. The presence vector is unaffected. Returning to polling mode restores the polled link bits.
- R8: Each port has its own polarity bit: 0 means a high pin is link up, 1 means a low pin is link up. A pin change reaches the link vector three clocks later.
- R9: Any change of the link vector sets the interrupt. The interrupt stays set until a write of 1 to bit 0 of word 3. A change in the same cycle as the clear wins.
- R10: After reset, both vectors are 0, the interrupt is 0, MDC is 0 and MDIO is not driven. The defaults are interval 200, mask 0x3, polling mode, active-high polarity, and port p at address p.
- R11: Word 0 holds the interval. Word 1 holds the address mask. Word 2 holds the mode: bit 0 selects pin mode, bit 1+p is the polarity of port p, and bits [4+5p +: 5] hold the address of port p. Word 3 is the interrupt clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| rx_link | input | NUM_PORTS | Per-port receive-link pins (asynchronous) |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| alive_vec | output | 32 | Presence vector, bit N for PHY address N |
| link_vec | output | 32 | Link vector, bit N for PHY address N |
| link_irq | output | 1 | Sticky link-change interrupt |

## Verification
Polled results appear one clock after the final MDC fall of a frame, and the link vector and interrupt follow one clock after that. The bench therefore lets a frame-driven scoreboard confirm that every expected frame has been seen, waits out the remaining turnaround and data bits plus a margin, and only then compares the vectors. A pin change is due three clocks after the drive, so pin-mode checks sample six clocks later. The PHY model checks frame fields and MDC period on each MDC rise. It measures the gap between rounds in clocks, from the last fall of one round to the first preamble rise of the next, and compares it against the interval window.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int PHY_AW = 5;
  localparam int NUM_PHY = 32;
  localparam logic [4:0] STATUS_REG = 5'd1;
  localparam int LINK_BIT = 2;

  typedef enum logic [1:0] {
    CFG_INTERVAL = 2'd0,
    CFG_MASK     = 2'd1,
    CFG_MODE     = 2'd2,
    CFG_IRQCLR   = 2'd3
  } cfg_word_e;

  typedef enum logic [1:0] {
    SC_WAIT = 2'd0,
    SC_SCAN = 2'd1,
    SC_BUSY = 2'd2
  } sched_state_e;

  typedef struct packed {
    logic [PHY_AW-1:0] addr;
    logic              ack;
    logic              link;
  } poll_res_t;
endpackage

// File: rtl/rx_link_sync.sv
module rx_link_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/mdio_read_engine.sv
module mdio_read_engine
  import mdio_poll_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic              mdio_i,
  output logic              busy,
  output logic              res_vld,
  output poll_res_t         res,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int CW = $clog2(DIV_HALF) + 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(DIV_HALF - 1);
  localparam int HDR_BITS = 46;
  localparam logic [5:0] HDR_LAST = 6'd45;
  localparam logic [5:0] ACK_IDX  = 6'd47;
  localparam logic [5:0] LINK_IDX = 6'(48 + 15 - LINK_BIT);
  localparam logic [5:0] LAST_IDX = 6'd63;

  logic [CW-1:0]       cnt;
  logic [5:0]          bit_cnt;
  logic [HDR_BITS-1:0] sh;
  logic [HDR_BITS-1:0] hdr;

  assign hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, phy_addr, STATUS_REG};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      res_vld <= 1'b0;
      res     <= '0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      cnt     <= '0;
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      res_vld <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          cnt      <= '0;
          bit_cnt  <= '0;
          sh       <= hdr;
          mdio_oe  <= 1'b1;
          mdio_o   <= hdr[HDR_BITS-1];
          res.addr <= phy_addr;
          res.ack  <= 1'b0;
          res.link <= 1'b0;
        end
      end else if (cnt == CNT_MAX) begin
        cnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (bit_cnt == ACK_IDX) res.ack <= ~mdio_i;
          if (bit_cnt == LINK_IDX) res.link <= mdio_i;
        end else begin
          mdc <= 1'b0;
          if (bit_cnt == LAST_IDX) begin
            busy    <= 1'b0;
            res_vld <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 6'd1;
            sh      <= {sh[HDR_BITS-2:0], 1'b0};
            mdio_o  <= sh[HDR_BITS-2];
            mdio_oe <= (bit_cnt < HDR_LAST);
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: clock is parked low whenever no frame is in flight
  a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R3: bus released for turnaround and data bits
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_cnt > HDR_LAST) |-> !mdio_oe);
  // R3: driven value only changes while MDC is low
  a_r3_change_low: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc);
endmodule

// File: rtl/mdio_poll_sched.sv
module mdio_poll_sched
  import mdio_poll_pkg::*;
#(
  parameter int TICK_CYC     = 100,
  parameter int INTV_W       = 16,
  parameter int MIN_INTERVAL = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTV_W-1:0] interval,
  input  logic [NUM_PHY-1:0] mask,
  input  logic              busy,
  input  logic              res_vld,
  output logic              start,
  output logic [PHY_AW-1:0] phy_addr
);
  localparam int TW = $clog2(TICK_CYC) + 1;
  localparam logic [TW-1:0] TICK_MAX = TW'(TICK_CYC - 1);
  localparam logic [INTV_W-1:0] MIN_IV = INTV_W'(MIN_INTERVAL);
  localparam logic [PHY_AW-1:0] LAST_ADDR = PHY_AW'(NUM_PHY - 1);

  sched_state_e      state;
  logic [TW-1:0]     tick_cnt;
  logic [INTV_W-1:0] us_cnt;
  logic [INTV_W-1:0] eff_iv;

  assign eff_iv = (interval < MIN_IV) ? MIN_IV : interval;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SC_WAIT;
      tick_cnt <= '0;
      us_cnt   <= '0;
      phy_addr <= '0;
      start    <= 1'b0;
    end else begin
      start <= 1'b0;
      case (state)
        SC_WAIT: begin
          if (tick_cnt == TICK_MAX) begin
            tick_cnt <= '0;
            if (us_cnt + 1'b1 >= eff_iv) begin
              us_cnt   <= '0;
              phy_addr <= '0;
              state    <= SC_SCAN;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
        SC_SCAN: begin
          if (mask[phy_addr] && !busy) begin
            start <= 1'b1;
            state <= SC_BUSY;
          end else if (!mask[phy_addr]) begin
            if (phy_addr == LAST_ADDR) begin
              tick_cnt <= '0;
              us_cnt   <= '0;
              state    <= SC_WAIT;
            end else begin
              phy_addr <= phy_addr + 1'b1;
            end
          end
        end
        SC_BUSY: begin
          if (res_vld) begin
            if (phy_addr == LAST_ADDR) begin
              tick_cnt <= '0;
              us_cnt   <= '0;
              state    <= SC_WAIT;
            end else begin
              phy_addr <= phy_addr + 1'b1;
              state    <= SC_SCAN;
            end
          end
        end
        default: state <= SC_WAIT;
      endcase
    end
  end

  // R5: a frame is only launched into an idle engine
  a_r5_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R5: address stays put while a frame is outstanding
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (state == SC_BUSY && !res_vld) |=> $stable(phy_addr));
endmodule

// File: rtl/mdio_link_poller.sv
module mdio_link_poller
  import mdio_poll_pkg::*;
#(
  parameter int DIV_HALF     = 20,
  parameter int TICK_CYC     = 100,
  parameter int INTV_W       = 16,
  parameter int DEF_INTERVAL = 200,
  parameter int MIN_INTERVAL = 10,
  parameter int NUM_PORTS    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  input  logic [NUM_PORTS-1:0] rx_link,
  input  logic                 mdio_i,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [NUM_PHY-1:0]   alive_vec,
  output logic [NUM_PHY-1:0]   link_vec,
  output logic                 link_irq
);
  localparam logic [INTV_W-1:0] DEF_IV = INTV_W'(DEF_INTERVAL);

  logic [INTV_W-1:0]  interval_r;
  logic [NUM_PHY-1:0] mask_r;
  logic               pin_mode;
  logic [NUM_PORTS-1:0] pol_low;
  logic [PHY_AW-1:0]  port_addr [NUM_PORTS];

  logic               start;
  logic [PHY_AW-1:0]  scan_addr;
  logic               eng_busy;
  logic               res_vld;
  poll_res_t          res;

  logic [NUM_PORTS-1:0] rx_sync;
  logic [NUM_PORTS-1:0] rx_act;
  logic [NUM_PHY-1:0] poll_link;
  logic [NUM_PHY-1:0] pin_vec;
  logic [NUM_PHY-1:0] link_nxt;
  logic               irq_clr;

  assign irq_clr = cfg_we && (cfg_addr == CFG_IRQCLR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      interval_r <= DEF_IV;
      mask_r     <= NUM_PHY'(3);
      pin_mode   <= 1'b0;
      pol_low    <= '0;
      for (int p = 0; p < NUM_PORTS; p++) port_addr[p] <= PHY_AW'(p);
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_INTERVAL: interval_r <= cfg_wdata[INTV_W-1:0];
        CFG_MASK:     mask_r     <= cfg_wdata;
        CFG_MODE: begin
          pin_mode <= cfg_wdata[0];
          for (int p = 0; p < NUM_PORTS; p++) begin
            pol_low[p]   <= cfg_wdata[1+p];
            port_addr[p] <= cfg_wdata[4+5*p +: 5];
          end
        end
        default: ;
      endcase
    end
  end

  mdio_poll_sched #(
    .TICK_CYC(TICK_CYC), .INTV_W(INTV_W), .MIN_INTERVAL(MIN_INTERVAL)
  ) sched_i (
    .clk(clk), .rst(rst), .interval(interval_r), .mask(mask_r),
    .busy(eng_busy), .res_vld(res_vld), .start(start), .phy_addr(scan_addr)
  );

  mdio_read_engine #(.DIV_HALF(DIV_HALF)) eng_i (
    .clk(clk), .rst(rst), .start(start), .phy_addr(scan_addr),
    .mdio_i(mdio_i), .busy(eng_busy), .res_vld(res_vld), .res(res),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  rx_link_sync #(.W(NUM_PORTS)) sync_i (
    .clk(clk), .rst(rst), .din(rx_link), .dout(rx_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pol
    assign rx_act[p] = rx_sync[p] ^ pol_low[p];
  end

  always_comb begin
    pin_vec = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rx_act[p]) pin_vec[port_addr[p]] = 1'b1;
  end

  assign link_nxt = pin_mode ? pin_vec : poll_link;

  always_ff @(posedge clk) begin
    if (rst) begin
      alive_vec <= '0;
      poll_link <= '0;
      link_vec  <= '0;
      link_irq  <= 1'b0;
    end else begin
      if (res_vld) begin
        alive_vec[res.addr] <= res.ack;
        poll_link[res.addr] <= res.ack & res.link;
      end
      link_vec <= link_nxt;
      if (link_nxt != link_vec) link_irq <= 1'b1;
      else if (irq_clr)         link_irq <= 1'b0;
    end
  end

  // R1 R2: presence bit follows the acknowledge of the finished frame
  a_r2_alive_tracks_ack: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> alive_vec[$past(res.addr)] == $past(res.ack));
  // R4: an unanswered read never leaves a polled link bit set
  a_r4_link_needs_ack: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res.ack) |=> !poll_link[$past(res.addr)]);
  // R9: every change of the link vector is flagged
  a_r9_irq_on_change: assert property (@(posedge clk) disable iff (rst)
    (link_vec != $past(link_vec)) |-> link_irq);
  // R9: flag holds until cleared
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (link_irq && !irq_clr) |=> link_irq);
endmodule

// File: tb/mdio_link_poller_tb.sv
module mdio_link_poller_tb_top;
  localparam int DIV_HALF = 2;
  localparam int TICK_CYC = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rx_link = '0;
  logic        mdio_i;
  logic        mdc, mdio_o, mdio_oe;
  logic [31:0] alive_vec, link_vec;
  logic        link_irq;

  logic        phy_drv = 1'b1;
  logic [31:0] phy_present = '0;
  logic [31:0] phy_up = '0;
  logic [31:0] mask_model = 32'h3;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int exp_q[$];
  int ones = 0;
  int idx = -1;
  logic [12:0] hdrb = '0;
  int last_fall = 0;
  int last_rise = 0;
  int meas_gap = 0;
  logic [17:0] resp = '1;
  int rcnt = 18;

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_link_poller #(.DIV_HALF(DIV_HALF), .TICK_CYC(TICK_CYC)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_link(rx_link), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .alive_vec(alive_vec), .link_vec(link_vec), .link_irq(link_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // PHY model drives turnaround and data on MDC falling edges
  always @(negedge mdc) begin
    last_fall = cyc;
    if (rcnt < 18) begin
      phy_drv = resp[17-rcnt];
      rcnt++;
    end else begin
      phy_drv = 1'b1;
    end
  end

  // Monitor: decodes frames and pops the scoreboard
  always @(posedge mdc) begin
    if (idx < 0) begin
      if (mdio_oe && mdio_o) begin
        if (ones == 0) meas_gap = cyc - last_fall;
        ones++;
      end else if (mdio_oe && !mdio_o) begin
        chk("R3 preamble length", ones, 32);
        ones = 0;
        idx = 33;
        hdrb = '0;
      end else begin
        ones = 0;
      end
    end else begin
      hdrb = {hdrb[11:0], mdio_o};
      if (idx == 40) chk("R3 mdc period", cyc - last_rise, 2*DIV_HALF);
      idx++;
      if (idx == 46) begin
        int a;
        a = int'(hdrb[9:5]);
        chk("R3 start/opcode", {29'd0, hdrb[12:10]}, 32'b110);
        chk("R3 register address", {27'd0, hdrb[4:0]}, 32'd1);
        chk("R5 address in mask", {31'd0, mask_model[a]}, 32'd1);
        if (exp_q.size() > 0) chk("R5 scan order", a, exp_q.pop_front());
        if (phy_present[a])
          resp = {1'b1, 1'b0, (16'h7809 | (phy_up[a] ? 16'h0004 : 16'h0000))};
        else
          resp = '1;
        rcnt = 0;
        idx = -1;
      end
    end
    last_rise = cyc;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input logic [31:0] m);
    wr(2'd1, 32'd0);
    wait_cyc(400);
    mask_model = m;
    wr(2'd1, m);
  endtask

  task automatic expect_round(input logic [31:0] m);
    for (int a = 0; a < 32; a++) if (m[a]) exp_q.push_back(a);
  endtask

  task automatic wait_q_empty();
    for (int i = 0; i < 8000; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    chk("R5 all expected frames seen", exp_q.size(), 0);
    wait_cyc(150);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 alive after reset", alive_vec, 0);
    chk("R10 link after reset", link_vec, 0);
    chk("R10 irq after reset", {31'd0, link_irq}, 0);
    chk("R10 mdc after reset", {31'd0, mdc}, 0);
    chk("R10 mdio_oe after reset", {31'd0, mdio_oe}, 0);

    // R11 interval word, R6 clamp to minimum
    wr(2'd0, 32'd3);
    phy_present = 32'h0000_0024;
    phy_up      = 32'h0000_0004;
    set_mask(32'h0000_0224);
    expect_round(32'h0000_0224);
    wait_q_empty();
    chk("R1 alive for answering PHYs", alive_vec, 32'h24);
    chk("R4 link only for ack and status bit", link_vec, 32'h04);
    chk("R9 irq raised on link change", {31'd0, link_irq}, 1);

    // R6 interval timing
    set_mask(32'h0000_0001);
    wait_cyc(2000);
    chk_rng("R6 gap at min interval", meas_gap, 10*TICK_CYC, 10*TICK_CYC + 80);
    wr(2'd0, 32'd30);
    wait_cyc(2500);
    chk_rng("R6 gap at interval 30", meas_gap, 30*TICK_CYC, 30*TICK_CYC + 80);

    // R1 R2 R4 on address 0
    phy_present[0] = 1'b1; phy_up[0] = 1'b1;
    wait_cyc(1300);
    chk("R1 alive set on ack", alive_vec, 32'h25);
    chk("R4 link up", link_vec, 32'h05);
    phy_up[0] = 1'b0;
    wait_cyc(1300);
    chk("R4 link down with ack", link_vec, 32'h04);
    chk("R1 alive kept with ack", alive_vec, 32'h25);
    phy_present[0] = 1'b0;
    wait_cyc(1300);
    chk("R2 alive cleared without ack, others kept", alive_vec, 32'h24);

    // R9 sticky flag and clear
    wr(2'd3, 32'd1);
    wait_cyc(3);
    chk("R9 irq cleared", {31'd0, link_irq}, 0);
    wait_cyc(1300);
    chk("R9 no irq without change", {31'd0, link_irq}, 0);
    phy_present[0] = 1'b1; phy_up[0] = 1'b1;
    wait_cyc(1300);
    chk("R9 irq after polled change", {31'd0, link_irq}, 1);
    chk("R4 link restored", link_vec, 32'h05);

    // R7 R8 pin mode
    set_mask(32'h0);
    wait_cyc(400);
    wr(2'd3, 32'd1);
    rx_link = 2'b01;
    wr(2'd2, 32'h0000_0E35);
    wait_cyc(6);
    chk("R8 port1 active-low pin low", link_vec, 32'h88);
    chk("R9 irq on pin mode change", {31'd0, link_irq}, 1);
    chk("R7 alive untouched in pin mode", alive_vec, 32'h25);
    wr(2'd3, 32'd1);
    wait_cyc(2);
    chk("R9 irq clear in pin mode", {31'd0, link_irq}, 0);
    @(negedge clk) rx_link = 2'b11;
    wait_cyc(6);
    chk("R8 port1 active-low pin high", link_vec, 32'h08);
    chk("R9 irq on pin change", {31'd0, link_irq}, 1);
    wr(2'd2, 32'h0000_0E31);
    wait_cyc(6);
    chk("R8 port1 active-high", link_vec, 32'h88);
    @(negedge clk) rx_link = 2'b00;
    wait_cyc(6);
    chk("R7 both pins inactive", link_vec, 32'h00);
    wr(2'd2, 32'h0000_0200);
    wait_cyc(3);
    chk("R7 polled link restored", link_vec, 32'h05);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule